// File: doc/BRIEF.md
# LVDS Seven-Slot Pixel Serializer

This block turns one RGB pixel per pixel period into the bit pattern of a seven-slot LVDS link. It runs on a bit clock seven times faster than the pixel rate. Each pixel period has seven time slots. In every slot, each active data lane carries one bit. A one-cycle load strobe marks each pixel boundary. On that strobe the block captures the 24-bit pixel, the data-enable and sync controls, and the mode selects. It then walks a slot counter through the seven slots and drives the matching clock-lane pattern beside the data lanes.

Two mode selects pick the bit layout. The first chooses one of two industry bit mappings: one puts the low color bits on lanes 0 to 2, the other puts the high color bits there. The second chooses three-lane (18-bit) or four-lane (24-bit) operation. The outputs are logic-level lane bits for a later differential driver stage. That driver stage, the PLL, the panel timing generator and the input multiplexer all live outside this block.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: A slot counter counts 0 to 6 on the bit clock and wraps from 6 to 0. A load strobe sampled at a clock edge forces slot 0 for the cycle after that edge, even in mid-pixel. The lanes show slot s of the captured pixel during that cycle.
- R2: The pixel (pix_i[23:16] red, [15:8] green, [7:0] blue), de_i, vs_i, hs_i, map_jeida_i and wide_i are captured only at a strobe edge. Changes at any other time have no effect on the lanes until the next strobe.
- R3: With map_jeida_i=0, lane 0 carries g0,r5,r4,r3,r2,r1,r0 and lane 1 carries b1,b0,g5,g4,g3,g2,g1 in slots 0 to 6.
- R4: With map_jeida_i=0, lane 2 carries de,vs,hs,b5,b4,b3,b2 and lane 3 carries 0,b7,b6,g7,g6,r7,r6 in slots 0 to 6.
- R5: With map_jeida_i=1, lane 0 carries g2,r7,r6,r5,r4,r3,r2 and lane 1 carries b3,b2,g7,g6,g5,g4,g3 in slots 0 to 6.
- R6: With map_jeida_i=1, lane 2 carries de,vs,hs,b7,b6,b5,b4 and lane 3 carries 0,b1,b0,g1,g0,r1,r0 in slots 0 to 6.
- R7: With wide_i=0 captured (18-bit), lane 3 is held at 0. Lanes 0 to 2 follow the captured mapping exactly as in 24-bit mode.
- R8: Lane 3 is 0 in slot 0 in every mode.
- R9: clk_lane_o follows the pattern 1,1,0,0,0,1,1 over slots 0 to 6, aligned with the data slots.
- R10: While rst_ni is low, and after reset until the first strobe edge, lane_o and clk_lane_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the pixel rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Pixel boundary strobe, one cycle |
| pix_i | input | 24 | Pixel: red [23:16], green [15:8], blue [7:0] |
| de_i | input | 1 | Data enable |
| vs_i | input | 1 | Vertical sync |
| hs_i | input | 1 | Horizontal sync |
| map_jeida_i | input | 1 | 0: low-bits-first mapping, 1: high-bits-first mapping |
| wide_i | input | 1 | 0: 18-bit / three lanes, 1: 24-bit / four lanes |
| lane_o | output | 4 | Data lane bits, lane n on bit n |
| clk_lane_o | output | 1 | Clock-lane bit for the current slot |

## Verification
Two events can land in the same cycle: a load strobe, and the counter's own step from one slot to the next. This happens when a strobe arrives early, in slot 2 or 4 instead of slot 6. It also happens when the mode selects change in that same cycle. The bench provokes both with shortened pixel runs and with selects that change right after each capture. It then checks that the next cycle shows slot 0 of the new pixel, in the newly captured layout, with the clock lane restarted at its first high bit. Runs of fourteen slots without a strobe check that the counter wraps on its own and replays the held pixel.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int COLOR_W  = 8;
  localparam int PIX_W    = 3 * COLOR_W;
  localparam int SLOTS    = 7;
  localparam int LANES    = 4;
  localparam int NARROW_LANES = 3;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011; // bit s = slot s

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
  } pixel_t;

  typedef struct packed {
    logic de;
    logic vs;
    logic hs;
  } ctrl_t;
endpackage

// File: rtl/lvds_slot_ctr.sv
module lvds_slot_ctr
  import lvds_ser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              active_o,
  output logic              clk_lane_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic              active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      slot_q   <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      slot_q   <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end
  end

  assign slot_o     = slot_q;
  assign active_o   = active_q;
  assign clk_lane_o = active_q & CLK_PATTERN[slot_q];

  // R1
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= LAST);
  // R1
  load_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (slot_q == '0) && active_q);
  // R1
  slot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !load_i && slot_q != LAST) |=> slot_q == $past(slot_q) + 1'b1);
  // R1
  slot_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !load_i && slot_q == LAST) |=> slot_q == '0);
endmodule

// File: rtl/lvds_pix_hold.sv
module lvds_pix_hold
  import lvds_ser_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  pixel_t pix_i,
  input  ctrl_t  ctrl_i,
  input  logic   jeida_i,
  input  logic   wide_i,
  output pixel_t pix_o,
  output ctrl_t  ctrl_o,
  output logic   jeida_o,
  output logic   wide_o
);
  pixel_t pix_q;
  ctrl_t  ctrl_q;
  logic   jeida_q, wide_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q   <= '0;
      ctrl_q  <= '0;
      jeida_q <= 1'b0;
      wide_q  <= 1'b0;
    end else if (load_i) begin
      pix_q   <= pix_i;
      ctrl_q  <= ctrl_i;
      jeida_q <= jeida_i;
      wide_q  <= wide_i;
    end
  end

  assign pix_o   = pix_q;
  assign ctrl_o  = ctrl_q;
  assign jeida_o = jeida_q;
  assign wide_o  = wide_q;

  // R2
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(pix_q) && $stable(ctrl_q) && $stable(jeida_q) && $stable(wide_q));
endmodule

// File: rtl/lvds_lane_map.sv
module lvds_lane_map
  import lvds_ser_pkg::*;
(
  input  pixel_t                       pix_i,
  input  ctrl_t                        ctrl_i,
  input  logic                         jeida_i,
  output logic [LANES-1:0][SLOTS-1:0]  word_o
);
  pixel_t p;
  assign p = pix_i;

  // Vectors are written slot 6 down to slot 0.
  always_comb begin
    if (jeida_i) begin
      word_o[0] = {p.r[2], p.r[3], p.r[4], p.r[5], p.r[6], p.r[7], p.g[2]};
      word_o[1] = {p.g[3], p.g[4], p.g[5], p.g[6], p.g[7], p.b[2], p.b[3]};
      word_o[2] = {p.b[4], p.b[5], p.b[6], p.b[7], ctrl_i.hs, ctrl_i.vs, ctrl_i.de};
      word_o[3] = {p.r[0], p.r[1], p.g[0], p.g[1], p.b[0], p.b[1], 1'b0};
    end else begin
      word_o[0] = {p.r[0], p.r[1], p.r[2], p.r[3], p.r[4], p.r[5], p.g[0]};
      word_o[1] = {p.g[1], p.g[2], p.g[3], p.g[4], p.g[5], p.b[0], p.b[1]};
      word_o[2] = {p.b[2], p.b[3], p.b[4], p.b[5], ctrl_i.hs, ctrl_i.vs, ctrl_i.de};
      word_o[3] = {p.r[6], p.r[7], p.g[6], p.g[7], p.b[6], p.b[7], 1'b0};
    end
  end
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              de_i,
  input  logic              vs_i,
  input  logic              hs_i,
  input  logic              map_jeida_i,
  input  logic              wide_i,
  output logic [LANES-1:0]  lane_o,
  output logic              clk_lane_o
);
  logic [SLOT_W-1:0]            slot;
  logic                         active;
  pixel_t                       pix_h;
  ctrl_t                        ctrl_h;
  logic                         jeida_h, wide_h;
  logic [LANES-1:0][SLOTS-1:0]  word;
  ctrl_t                        ctrl_in;

  assign ctrl_in = '{de: de_i, vs: vs_i, hs: hs_i};

  lvds_slot_ctr u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .slot_o     (slot),
    .active_o   (active),
    .clk_lane_o (clk_lane_o)
  );

  lvds_pix_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .pix_i   (pixel_t'(pix_i)),
    .ctrl_i  (ctrl_in),
    .jeida_i (map_jeida_i),
    .wide_i  (wide_i),
    .pix_o   (pix_h),
    .ctrl_o  (ctrl_h),
    .jeida_o (jeida_h),
    .wide_o  (wide_h)
  );

  lvds_lane_map u_map (
    .pix_i   (pix_h),
    .ctrl_i  (ctrl_h),
    .jeida_i (jeida_h),
    .word_o  (word)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l < NARROW_LANES) begin : g_base
      assign lane_o[l] = active & word[l][slot];
    end else begin : g_wide
      assign lane_o[l] = active & wide_h & word[l][slot];
    end
  end

  // R10
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (lane_o == '0) && !clk_lane_o);
  // R7
  narrow_lane3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_h |-> !lane_o[LANES-1]);
  // R8
  lane3_slot0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot == '0) |-> !lane_o[LANES-1]);
  // R9
  clk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(clk_lane_o) && !$past(load_i)) |-> slot == SLOT_W'(5));
endmodule

// File: tb/sim_lvds_pixel_serializer.sv
module sim_lvds_pixel_serializer;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [23:0] pix = '0;
  logic        de = 1'b0, vs = 1'b0, hs = 1'b0, jeida = 1'b0, wide = 1'b0;
  logic [3:0]  lane;
  logic        clk_lane;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvds_pixel_serializer u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .pix_i(pix),
    .de_i(de), .vs_i(vs), .hs_i(hs), .map_jeida_i(jeida), .wide_i(wide),
    .lane_o(lane), .clk_lane_o(clk_lane)
  );

  // Expected lane bits from the requirement tables (R3..R8).
  function automatic logic [3:0] exp_lanes(logic [23:0] p, logic e, logic v, logic h,
                                           logic j, logic w, int s);
    logic [7:0] r, g, b;
    logic l0, l1, l2, l3;
    r = p[23:16]; g = p[15:8]; b = p[7:0];
    l0 = 0; l1 = 0; l2 = 0; l3 = 0;
    if (!j) begin
      case (s)
        0: begin l0 = g[0]; l1 = b[1]; l2 = e;    l3 = 1'b0; end
        1: begin l0 = r[5]; l1 = b[0]; l2 = v;    l3 = b[7]; end
        2: begin l0 = r[4]; l1 = g[5]; l2 = h;    l3 = b[6]; end
        3: begin l0 = r[3]; l1 = g[4]; l2 = b[5]; l3 = g[7]; end
        4: begin l0 = r[2]; l1 = g[3]; l2 = b[4]; l3 = g[6]; end
        5: begin l0 = r[1]; l1 = g[2]; l2 = b[3]; l3 = r[7]; end
        default: begin l0 = r[0]; l1 = g[1]; l2 = b[2]; l3 = r[6]; end
      endcase
    end else begin
      case (s)
        0: begin l0 = g[2]; l1 = b[3]; l2 = e;    l3 = 1'b0; end
        1: begin l0 = r[7]; l1 = b[2]; l2 = v;    l3 = b[1]; end
        2: begin l0 = r[6]; l1 = g[7]; l2 = h;    l3 = b[0]; end
        3: begin l0 = r[5]; l1 = g[6]; l2 = b[7]; l3 = g[1]; end
        4: begin l0 = r[4]; l1 = g[5]; l2 = b[6]; l3 = g[0]; end
        5: begin l0 = r[3]; l1 = g[4]; l2 = b[5]; l3 = r[1]; end
        default: begin l0 = r[2]; l1 = g[3]; l2 = b[4]; l3 = r[0]; end
      endcase
    end
    if (!w) l3 = 1'b0;
    return {l3, l2, l1, l0};
  endfunction

  function automatic logic exp_clk(int s);
    return (s <= 1) || (s >= 5);
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, expv);
    end
  endtask

  task automatic scramble();
    pix = $urandom; de = $urandom; vs = $urandom; hs = $urandom;
    jeida = $urandom; wide = $urandom;
  endtask

  // Called at a negedge: strobe one pixel, then check nslots slots.
  task automatic run_pix(logic [23:0] p, logic e, logic v, logic h,
                         logic j, logic w, int nslots);
    string tag;
    load = 1'b1; pix = p; de = e; vs = v; hs = h; jeida = j; wide = w;
    @(posedge clk); #1;
    load = 1'b0;
    scramble(); // R2: later input changes must not reach the lanes
    tag = j ? "R5 R6 R8 R2 R1" : "R3 R4 R8 R2 R1";
    if (!w) tag = {tag, " R7"};
    for (int s = 0; s < nslots; s++) begin
      @(negedge clk);
      check(tag, {1'b0, lane}, {1'b0, exp_lanes(p, e, v, h, j, w, s % 7)});
      check("R9", {4'b0, clk_lane}, {4'b0, exp_clk(s % 7)}); // R9
      if (s % 3 == 1) scramble();
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    // R10: reset holds everything at zero
    #(CLK_PERIOD*2);
    @(negedge clk);
    check("R10", {lane, clk_lane}, 5'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      scramble();
      @(negedge clk);
      check("R10", {lane, clk_lane}, 5'b0); // before first strobe
    end
    @(negedge clk);
    // Directed: each bit alone, both mappings, both widths (R3 R4 R5 R6 R7)
    for (int k = 0; k < 24; k++) begin
      run_pix(24'h1 << k, 1'b0, 1'b0, 1'b0, k[0], 1'b1, 7);
      run_pix(24'h1 << k, 1'b0, 1'b0, 1'b0, ~k[0], k[1], 7);
    end
    run_pix(24'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 7); // controls alone (R4)
    run_pix(24'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 7); // (R6)
    run_pix(24'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7);
    run_pix(24'hFFFFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 7); // R8 with all ones
    run_pix(24'hFFFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 7); // R7 all ones narrow
    // R1: early strobes and free-running wrap
    run_pix(24'hA5C33C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3);
    run_pix(24'h5A3CC3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5);
    run_pix(24'h123456, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 14);
    run_pix(24'h654321, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1);
    // Random mix
    for (int n = 0; n < 300; n++) begin
      int len;
      len = (n % 5 == 0) ? 1 + ($urandom % 13) : 7;
      run_pix($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, len);
    end
    // R10: asynchronous reset in mid-pixel, then idle until next strobe
    load = 1'b1; pix = 24'hFFFFFF; wide = 1'b1; de = 1'b1;
    @(posedge clk); #1; load = 1'b0;
    @(negedge clk); #(CLK_PERIOD/4);
    rst_n = 1'b0; #1;
    check("R10", {lane, clk_lane}, 5'b0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R10", {lane, clk_lane}, 5'b0);
    end
    run_pix(24'hC0FFEE, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 7);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule